// File: doc/BRIEF.md
# Multicast Tree Identifier Lookup Table

This block sits at the network interface of one node and keeps a small table of the multicast trees that the node is using. Each tree is known by its destination set, a bit-vector with one bit per node. A caller presents a destination set. The table answers with the identifier of a stored tree that reaches those destinations, or it reports a miss. On a miss the table claims a slot for a new tree, either the lowest free slot or the least recently used one. It returns that slot's identifier with a flag that tells the caller the tree must still be set up in the network.

Several address regions often have the same sharer set. All of them resolve to the same table entry, so one tree serves them all. When a region gains a sharer, the caller looks up the larger set as a new search. With `allow_superset` high, a stored tree may be reused if it reaches every requested destination plus at most `MAX_EXTRA` others. This lets a small table do the work of a much larger exact-match table, at the cost of some extra traffic. The answer is registered and appears one clock after the search.

Top module: `tree_id_cam`

## Requirements
- R1: After reset the table holds no entries and `result_valid` is low.
- R2: A search whose set equals a stored set returns that entry's identifier with `result_hit`=1, `result_setup`=0 and `result_extra`=0.
- R3: A search that matches no entry while a free slot exists gives `result_hit`=0 and `result_setup`=1. It returns the lowest free slot index and stores the set there.
- R4: With `allow_superset`=1, a stored set that contains every requested bit is a hit, and `result_extra` gives the number of stored bits outside the request. With `allow_superset`=0, only equal sets hit.
- R5: A stored superset with more than `MAX_EXTRA` extra destinations is never used. The search is then a miss.
- R6: An exact match beats any superset match. Among superset matches, the one with the fewest extra destinations wins, and a tie goes to the lowest index.
- R7: A miss on a full table replaces the least recently used entry. Both hits and allocations count as uses.
- R8: A result is valid exactly one cycle after a search. With no search, `result_valid` is low in the next cycle.
- R9: Repeated searches with the same set, as from several regions with one sharer set, return the same identifier and allocate nothing new.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| search_valid | input | 1 | A search is presented this cycle |
| search_set | input | NODES | Requested destination bit-vector, bit i = node i |
| allow_superset | input | 1 | 1: superset reuse allowed; 0: exact match only |
| result_valid | output | 1 | Result of the previous cycle's search |
| result_hit | output | 1 | 1: an existing tree was found |
| result_setup | output | 1 | 1: a slot was allocated and its tree needs setup |
| result_id | output | $clog2(ENTRIES) | Tree identifier (table slot) |
| result_extra | output | $clog2(NODES+1) | Count of extra destinations in the reused tree |

## Verification
Wrong stored sets or valid bits show up at the ports on the next search of that set: a miss where a hit was due, a stale identifier, or a slot index that repeats. A faulty recency order stays hidden until the table is full. The first miss after that then picks the wrong victim, and a later search of the evicted set reveals it. A wrong choice among several candidates appears only when two or more entries cover one request, so the sweep draws sets from a narrow bit range to make overlaps common.

// File: rtl/tid_pkg.sv
package tid_pkg;
   typedef enum logic [1:0] {
      MK_NONE  = 2'd0,
      MK_EXACT = 2'd1,
      MK_SUPER = 2'd2
   } match_kind_e;
endpackage

// File: rtl/tid_cell.sv
module tid_cell
   import tid_pkg::*;
#(
   parameter int NODES     = 16,
   parameter int MAX_EXTRA = 2,
   localparam int XW       = $clog2(NODES + 1)
) (
   input  logic             entry_valid,
   input  logic [NODES-1:0] entry_set,
   input  logic [NODES-1:0] req_set,
   input  logic             allow_super,
   output match_kind_e      kind,
   output logic [XW-1:0]    extra
);
   logic missing;

   always_comb begin
      extra   = XW'($countones(entry_set & ~req_set));
      missing = |(req_set & ~entry_set);
      if (!entry_valid)
         kind = MK_NONE;
      else if (entry_set == req_set)
         kind = MK_EXACT;
      else if (allow_super && !missing && (int'(extra) <= MAX_EXTRA))
         kind = MK_SUPER;
      else
         kind = MK_NONE;
   end
endmodule

// File: rtl/tid_pick.sv
module tid_pick #(
   parameter int ENTRIES = 8,
   parameter int XW      = 5,
   localparam int IW     = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0]    is_exact,
   input  logic [ENTRIES-1:0]    is_super,
   input  logic [ENTRIES*XW-1:0] extras,
   output logic                  hit,
   output logic [IW-1:0]         hit_idx,
   output logic [XW-1:0]         hit_extra
);
   logic          have_ex, have_sup;
   logic [IW-1:0] ex_idx, sup_idx;
   logic [XW-1:0] sup_x;

   always_comb begin
      have_ex  = 1'b0;
      have_sup = 1'b0;
      ex_idx   = '0;
      sup_idx  = '0;
      sup_x    = '0;
      // Scan downward so that ties settle on the lowest index.
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (is_exact[i]) begin
            have_ex = 1'b1;
            ex_idx  = IW'(i);
         end
         if (is_super[i] && (!have_sup || extras[i*XW +: XW] <= sup_x)) begin
            have_sup = 1'b1;
            sup_idx  = IW'(i);
            sup_x    = extras[i*XW +: XW];
         end
      end
      hit       = have_ex | have_sup;
      hit_idx   = have_ex ? ex_idx : sup_idx;
      hit_extra = have_ex ? '0 : sup_x;
   end
endmodule

// File: rtl/tid_lru.sv
module tid_lru #(
   parameter int ENTRIES = 8,
   localparam int IW     = $clog2(ENTRIES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch,
   input  logic [IW-1:0] touch_idx,
   output logic [IW-1:0] victim
);
   // Ages form a permutation of 0..ENTRIES-1; 0 is most recent.
   logic [IW-1:0] age [ENTRIES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int j = 0; j < ENTRIES; j++) age[j] <= IW'(j);
      end else if (touch) begin
         for (int j = 0; j < ENTRIES; j++) begin
            if (IW'(j) == touch_idx)
               age[j] <= '0;
            else if (age[j] < age[touch_idx])
               age[j] <= age[j] + 1'b1;
         end
      end
   end

   always_comb begin
      victim = '0;
      for (int j = 0; j < ENTRIES; j++)
         if (age[j] == IW'(ENTRIES - 1)) victim = IW'(j);
   end
endmodule

// File: rtl/tree_id_cam.sv
module tree_id_cam
   import tid_pkg::*;
#(
   parameter int NODES     = 16,
   parameter int ENTRIES   = 8,
   parameter int MAX_EXTRA = 2,
   localparam int IW       = $clog2(ENTRIES),
   localparam int XW       = $clog2(NODES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             search_valid,
   input  logic [NODES-1:0] search_set,
   input  logic             allow_superset,
   output logic             result_valid,
   output logic             result_hit,
   output logic             result_setup,
   output logic [IW-1:0]    result_id,
   output logic [XW-1:0]    result_extra
);
   if (ENTRIES < 2 || (1 << IW) != ENTRIES) begin : g_bad_entries
      $error("tree_id_cam: ENTRIES must be a power of two of at least 2");
   end
   if (MAX_EXTRA < 0 || MAX_EXTRA >= NODES) begin : g_bad_extra
      $error("tree_id_cam: MAX_EXTRA must lie in 0..NODES-1");
   end

   logic [NODES-1:0]    tbl_set [ENTRIES];
   logic [ENTRIES-1:0]  tbl_val;
   logic [ENTRIES-1:0]  is_exact, is_super;
   logic [ENTRIES*XW-1:0] extras;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
      match_kind_e   k;
      logic [XW-1:0] x;
      tid_cell #(.NODES(NODES), .MAX_EXTRA(MAX_EXTRA)) u_cell (
         .entry_valid (tbl_val[g]),
         .entry_set   (tbl_set[g]),
         .req_set     (search_set),
         .allow_super (allow_superset),
         .kind        (k),
         .extra       (x)
      );
      assign is_exact[g]          = (k == MK_EXACT);
      assign is_super[g]          = (k == MK_SUPER);
      assign extras[g*XW +: XW]   = x;
   end

   logic          hit;
   logic [IW-1:0] hit_idx, victim, free_idx, alloc_idx;
   logic [XW-1:0] hit_extra;
   logic          any_free;

   tid_pick #(.ENTRIES(ENTRIES), .XW(XW)) u_pick (
      .is_exact  (is_exact),
      .is_super  (is_super),
      .extras    (extras),
      .hit       (hit),
      .hit_idx   (hit_idx),
      .hit_extra (hit_extra)
   );

   always_comb begin
      any_free = ~&tbl_val;
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--)
         if (!tbl_val[i]) free_idx = IW'(i);
      alloc_idx = any_free ? free_idx : victim;
   end

   tid_lru #(.ENTRIES(ENTRIES)) u_lru (
      .clk       (clk),
      .rst_n     (rst_n),
      .touch     (search_valid),
      .touch_idx (hit ? hit_idx : alloc_idx),
      .victim    (victim)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tbl_val <= '0;
         for (int i = 0; i < ENTRIES; i++) tbl_set[i] <= '0;
      end else if (search_valid && !hit) begin
         tbl_val[alloc_idx] <= 1'b1;
         tbl_set[alloc_idx] <= search_set;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_valid <= 1'b0;
         result_hit   <= 1'b0;
         result_setup <= 1'b0;
         result_id    <= '0;
         result_extra <= '0;
      end else begin
         result_valid <= search_valid;
         result_hit   <= search_valid & hit;
         result_setup <= search_valid & ~hit;
         if (search_valid) begin
            result_id    <= hit ? hit_idx : alloc_idx;
            result_extra <= hit ? hit_extra : '0;
         end
      end
   end
endmodule

// File: rtl/tree_id_cam_chk.sv
module tree_id_cam_chk #(
   parameter int NODES     = 16,
   parameter int ENTRIES   = 8,
   parameter int MAX_EXTRA = 2,
   localparam int XW       = $clog2(NODES + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          search_valid,
   input logic          allow_superset,
   input logic          result_valid,
   input logic          result_hit,
   input logic          result_setup,
   input logic [XW-1:0] result_extra
);
   // R8: a search yields a result one cycle later
   assert_result_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      search_valid |=> result_valid);

   // R8: no search, no result
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !search_valid |=> !result_valid);

   // R3: exactly one of hit and setup on every valid result
   assert_setup_on_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> (result_setup != result_hit));

   // R5: a reused tree never exceeds the extra-destination bound
   assert_extra_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && result_hit) |-> (int'(result_extra) <= MAX_EXTRA));

   // R4: exact-only searches never report extra destinations
   assert_exact_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (search_valid && !allow_superset) |=> (result_extra == '0));

   // R2: results without a search carry no hit or setup
   assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !result_valid |-> (!result_hit && !result_setup));
endmodule

bind tree_id_cam tree_id_cam_chk #(
   .NODES(NODES), .ENTRIES(ENTRIES), .MAX_EXTRA(MAX_EXTRA)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .search_valid   (search_valid),
   .allow_superset (allow_superset),
   .result_valid   (result_valid),
   .result_hit     (result_hit),
   .result_setup   (result_setup),
   .result_extra   (result_extra)
);

// File: tb/tb_tree_id_cam.sv
`timescale 1ns/1ps
module tb_tree_id_cam;
   localparam int N  = 8;
   localparam int E  = 4;
   localparam int MX = 2;
   localparam int IW = $clog2(E);
   localparam int XW = $clog2(N + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          search_valid = 1'b0;
   logic [N-1:0]  search_set = '0;
   logic          allow_superset = 1'b0;
   logic          result_valid, result_hit, result_setup;
   logic [IW-1:0] result_id;
   logic [XW-1:0] result_extra;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   tree_id_cam #(.NODES(N), .ENTRIES(E), .MAX_EXTRA(MX)) dut (
      .clk(clk), .rst_n(rst_n), .search_valid(search_valid),
      .search_set(search_set), .allow_superset(allow_superset),
      .result_valid(result_valid), .result_hit(result_hit),
      .result_setup(result_setup), .result_id(result_id),
      .result_extra(result_extra)
   );

   // Reference model built from the requirements
   logic [N-1:0] mset [E];
   bit           mval [E];
   int           mstamp [E];
   int           now = 0;

   task automatic check1(input string tag, input bit ok, input string msg);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: %s", tag, msg);
      end
   endtask

   task automatic search(input logic [N-1:0] s, input bit sup, input string tag_in);
      bit  e_hit; int e_id; int e_x; bit full; string tag;
      int  best; int bx;
      e_hit = 0; e_id = 0; e_x = 0; best = -1; bx = 0;
      for (int i = 0; i < E; i++)
         if (mval[i] && mset[i] == s && !e_hit) begin e_hit = 1; e_id = i; end
      if (!e_hit && sup) begin
         for (int i = 0; i < E; i++) begin
            int x;
            x = $countones(mset[i] & ~s);
            if (mval[i] && ((s & ~mset[i]) == 0) && x <= MX && (best < 0 || x < bx)) begin
               best = i; bx = x;
            end
         end
         if (best >= 0) begin e_hit = 1; e_id = best; e_x = bx; end
      end
      full = 1;
      for (int i = 0; i < E; i++) if (!mval[i]) full = 0;
      if (!e_hit) begin
         if (!full) begin
            for (int i = E - 1; i >= 0; i--) if (!mval[i]) e_id = i;
         end else begin
            e_id = 0;
            for (int i = 1; i < E; i++) if (mstamp[i] < mstamp[e_id]) e_id = i;
         end
      end
      tag = tag_in;
      if (tag == "") tag = !e_hit ? (full ? "R7" : "R3") : (e_x > 0 ? "R6" : "R2");

      search_valid   = 1'b1;
      search_set     = s;
      allow_superset = sup;
      @(negedge clk);
      check1(tag, result_valid && result_hit == e_hit && result_setup == !e_hit
                  && int'(result_id) == e_id && int'(result_extra) == e_x,
             $sformatf("set=%h sup=%0d got v=%0d hit=%0d setup=%0d id=%0d x=%0d exp hit=%0d id=%0d x=%0d",
                       s, sup, result_valid, result_hit, result_setup, result_id,
                       result_extra, e_hit, e_id, e_x));
      search_valid = 1'b0;
      now++;
      mstamp[e_id] = now;
      if (!e_hit) begin mval[e_id] = 1; mset[e_id] = s; end
   endtask

   initial begin : watchdog
      #2000000;
      failures++;
      $display("FAIL watchdog: run hung, got no end expected end");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < E; i++) begin mval[i] = 0; mset[i] = '0; mstamp[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check1("R1", result_valid == 1'b0, $sformatf("result_valid got %0d exp 0", result_valid));

      search(8'h03, 0, "R3");   // empty table: slot 0, setup
      search(8'h03, 0, "R9");   // second region with same sharers
      search(8'h03, 1, "R9");
      search(8'h0C, 0, "R3");   // slot 1
      search(8'h01, 1, "R4");   // superset of slot 0, one extra
      search(8'h01, 0, "R4");   // exact-only: miss, slot 2
      search(8'h01, 1, "R6");   // exact slot 2 beats superset slot 0
      search(8'hF0, 0, "R3");   // slot 3, table now full
      search(8'h10, 1, "R5");   // F0 has three extras: miss, LRU victim
      search(8'h0C, 0, "R7");   // slot 1 was evicted: miss again
      search(8'h03, 0, "R7");   // recency after hits
      @(negedge clk);
      check1("R8", result_valid == 1'b0, $sformatf("idle result_valid got %0d exp 0", result_valid));

      for (int n = 0; n < 500; n++) begin
         logic [N-1:0] s;
         s = N'($urandom) & 8'h1F;
         search(s, 1'($urandom), "");
         if (n % 37 == 0) begin
            @(negedge clk);
            check1("R8", result_valid == 1'b0, $sformatf("idle result_valid got %0d exp 0", result_valid));
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule